// File: doc/BRIEF.md
# Standby Wake-up Sequencer

This block decides when a small microcontroller's oscillators run and when its core is held in reset around low-power periods. From the run state, a stop request parks the core in one of two stop flavours: main-stop, where only the main oscillator is halted, or sub-stop, where both oscillators are halted. The core leaves stop on a reset source or on an interrupt request at a real priority level. It always lets the relevant oscillator settle for a fixed number of clock cycles before it lets go. The main-clock settling time is chosen by a 2-bit field. The sub-clock settling time is a parameter.

After the settling time, an interrupt-caused exit gives a one-cycle wake status. That status says whether the core takes the interrupt, which depends on the acceptance decision the interrupt logic supplies, or resumes at the instruction after the stop. A reset-caused exit gives a one-cycle internal reset pulse instead.

An active-low hardware-standby pin overrides all of this. While the pin is low, both oscillators are disabled, the I/O pads are forced to high impedance, and the register-clear and internal reset outputs are held. These outputs react to the raw pin without waiting for a clock edge. Standby ends only when the pin rises. The rise is synchronised, the main-clock settling time runs with the internal reset held, and then the core starts from reset.

Top module: `stby_wake_seq`

## Requirements
- R1: While hst_ni is low or rst_ni is low, io_hiz_o=1, reg_clr_o=1, int_rst_o=1, main_osc_en_o=0 and sub_osc_en_o=0. A falling hst_ni forces these values at once, with no clock edge.
- R2: Standby is left only through hst_ni. stop_req_i, ext_rst_i and irq_lvl_i have no effect while hst_ni is low. After hst_ni (or rst_ni) rises just before edge 1, int_rst_o falls after edge N+3, where N is the main settling time. The main oscillator runs from edge 3 on.
- R3: In run, stop_req_i=1 enters stop at the next edge. With sub_mode_i=0 (main-stop), main_osc_en_o=0 and sub_osc_en_o=1. With sub_mode_i=1 (sub-stop), both are 0.
- R4: irq_lvl_i values 0 to 6 are interrupt requests. Value 7 means no request and never wakes the block from stop.
- R5: The main settling time N is 2^(4+4*wait_sel_i): 16, 256, 4096 and 65536 cycles for codes 0, 1, 2 and 3.
- R6: The sub-stop settling time is SUB_WAIT_CYC cycles (default 64).
- R7: With a wake event present just before edge 1, an interrupt-caused exit raises wake_valid_o for exactly one cycle after edge N+1. wake_take_irq_o equals irq_accept_i sampled at that edge and is 0 whenever wake_valid_o is 0.
- R8: A reset-caused exit raises int_rst_o for exactly one cycle after edge N+1, with no wake_valid_o. When ext_rst_i and an interrupt arrive together, the reset cause wins.
- R9: Once the settling wait has started, further ext_rst_i or interrupt requests and changes of wait_sel_i neither restart it, shorten it, nor change its cause. The settling time is taken from wait_sel_i when stop is entered.
- R10: In run, ext_rst_i=1 for one cycle gives a one-cycle int_rst_o pulse after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on sequencer clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| hst_ni | input | 1 | Hardware-standby pin, active low, asynchronous |
| stop_req_i | input | 1 | Request to enter stop from run |
| sub_mode_i | input | 1 | Stop flavour: 0 main-stop, 1 sub-stop |
| ext_rst_i | input | 1 | Reset source request |
| irq_lvl_i | input | 3 | Highest pending interrupt level, 7 = none |
| irq_accept_i | input | 1 | The core would accept the pending interrupt |
| wait_sel_i | input | 2 | Main oscillator settling-time select |
| main_osc_en_o | output | 1 | Main oscillator enable |
| sub_osc_en_o | output | 1 | Sub oscillator enable |
| io_hiz_o | output | 1 | Force I/O pads to high impedance |
| reg_clr_o | output | 1 | Clear accumulator and dedicated registers |
| int_rst_o | output | 1 | Internal core reset |
| wake_valid_o | output | 1 | One-cycle pulse: interrupt-caused wake complete |
| wake_take_irq_o | output | 1 | With wake_valid_o: 1 take interrupt, 0 resume |

## Verification
The bench runs a main-stop exit for every wait-select code and counts the edges up to the wake pulse. An off-by-one counter, or a wrong shift in the settling-time table, shows up as a count one cycle off or off by a power of two. Requests, reset pulses and wait-select changes are injected in the middle of a wait: a design that restarts the timer comes out late, and one that re-latches the cause or the select gives the wrong pulse or the wrong length. The standby pin is dropped in run and in mid-wait, and the outputs are checked before any clock edge, which catches a design that only samples the pin. A simultaneous reset and interrupt in sub-stop checks that the reset wins and that no wake status leaks out.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef enum logic [2:0] {
    ST_HSTBY = 3'd0,
    ST_HWAIT = 3'd1,
    ST_RUN   = 3'd2,
    ST_STOP  = 3'd3,
    ST_SWAIT = 3'd4
  } sbw_state_e;
endpackage

// File: rtl/sbw_sync.sv
module sbw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sr_q <= '0;
    else          sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/sbw_stab_timer.sv
module sbw_stab_timer #(
  parameter int CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  // cleared whenever idle, so every wait starts from zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/stby_wake_seq.sv
module stby_wake_seq
  import sbw_pkg::*;
#(
  parameter int IRQ_W          = 3,
  parameter int WAIT_BASE_LOG2 = 4,
  parameter int WAIT_STEP_LOG2 = 4,
  parameter int SUB_WAIT_CYC   = 64,
  parameter int SYNC_STAGES    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hst_ni,
  input  logic             stop_req_i,
  input  logic             sub_mode_i,
  input  logic             ext_rst_i,
  input  logic [IRQ_W-1:0] irq_lvl_i,
  input  logic             irq_accept_i,
  input  logic [1:0]       wait_sel_i,
  output logic             main_osc_en_o,
  output logic             sub_osc_en_o,
  output logic             io_hiz_o,
  output logic             reg_clr_o,
  output logic             int_rst_o,
  output logic             wake_valid_o,
  output logic             wake_take_irq_o
);
  localparam int CNT_W = WAIT_BASE_LOG2 + 3 * WAIT_STEP_LOG2 + 1;
  localparam logic [IRQ_W-1:0] LVL_NONE = '1;
  localparam logic [CNT_W-1:0] SUB_LEN = CNT_W'(SUB_WAIT_CYC);

  function automatic logic [CNT_W-1:0] main_len(input logic [1:0] sel);
    return CNT_W'(1) << (WAIT_BASE_LOG2 + WAIT_STEP_LOG2 * int'(sel));
  endfunction

  sbw_state_e       state_q, state_d;
  logic [CNT_W-1:0] lim_q;
  logic             sub_q, cause_rst_q;
  logic             wake_vld_q, take_q, rst_pls_q;
  logic             hst_ok, timer_run, timer_done, wake_evt;
  logic             sync_arst_n;

  assign sync_arst_n = rst_ni & hst_ni;

  sbw_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .arst_ni(sync_arst_n),
    .q_o    (hst_ok)
  );

  assign timer_run = (state_q == ST_HWAIT) || (state_q == ST_SWAIT);

  sbw_stab_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (timer_run),
    .limit_i(lim_q),
    .done_o (timer_done)
  );

  assign wake_evt = ext_rst_i || (irq_lvl_i != LVL_NONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HSTBY: if (hst_ok) state_d = ST_HWAIT;
      ST_HWAIT: if (timer_done) state_d = ST_RUN;
      ST_RUN:   if (!ext_rst_i && stop_req_i) state_d = ST_STOP;
      ST_STOP:  if (wake_evt) state_d = ST_SWAIT;
      ST_SWAIT: if (timer_done) state_d = ST_RUN;
      default:  state_d = ST_HSTBY;
    endcase
    if (!hst_ok) state_d = ST_HSTBY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_HSTBY;
      lim_q       <= '0;
      sub_q       <= 1'b0;
      cause_rst_q <= 1'b0;
      wake_vld_q  <= 1'b0;
      take_q      <= 1'b0;
      rst_pls_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      wake_vld_q <= 1'b0;
      take_q     <= 1'b0;
      rst_pls_q  <= 1'b0;
      if (state_q == ST_HSTBY && state_d == ST_HWAIT) lim_q <= main_len(wait_sel_i);
      if (state_q == ST_RUN && state_d == ST_STOP) begin
        sub_q <= sub_mode_i;
        lim_q <= sub_mode_i ? SUB_LEN : main_len(wait_sel_i);
      end
      if (state_q == ST_RUN && state_d == ST_RUN && ext_rst_i) rst_pls_q <= 1'b1;
      if (state_q == ST_STOP && state_d == ST_SWAIT) cause_rst_q <= ext_rst_i;
      if (state_q == ST_SWAIT && state_d == ST_RUN) begin
        if (cause_rst_q) rst_pls_q <= 1'b1;
        else begin
          wake_vld_q <= 1'b1;
          take_q     <= irq_accept_i;
        end
      end
    end
  end

  // raw pin gates outputs so standby needs no clock edge
  assign main_osc_en_o   = hst_ni && (state_q != ST_HSTBY) && (state_q != ST_STOP);
  assign sub_osc_en_o    = hst_ni && (state_q != ST_HSTBY) && !(state_q == ST_STOP && sub_q);
  assign io_hiz_o        = !hst_ni || (state_q == ST_HSTBY);
  assign reg_clr_o       = !hst_ni || (state_q == ST_HSTBY);
  assign int_rst_o       = !hst_ni || (state_q == ST_HSTBY) || (state_q == ST_HWAIT) || rst_pls_q;
  assign wake_valid_o    = wake_vld_q;
  assign wake_take_irq_o = take_q;
endmodule

// File: rtl/sbw_checker.sv
module sbw_checker
  import sbw_pkg::*;
#(
  parameter int IRQ_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hst_ni,
  input logic             ext_rst_i,
  input logic [IRQ_W-1:0] irq_lvl_i,
  input logic             main_osc_en_o,
  input logic             sub_osc_en_o,
  input logic             io_hiz_o,
  input logic             reg_clr_o,
  input logic             int_rst_o,
  input logic             wake_valid_o,
  input logic             wake_take_irq_o,
  input sbw_state_e       state_q
);
  a_r1_pin_low_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hst_ni |-> (io_hiz_o && reg_clr_o && int_rst_o && !main_osc_en_o && !sub_osc_en_o));

  a_r2_standby_exit_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HSTBY) |=> (state_q == ST_HSTBY || state_q == ST_HWAIT));

  a_r3_stop_main_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) |-> !main_osc_en_o);

  a_r4_no_request_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && irq_lvl_i == '1 && !ext_rst_i) |=>
    (state_q == ST_STOP || state_q == ST_HSTBY));

  a_r7_wake_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_valid_o |=> !wake_valid_o);

  a_r7_take_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_take_irq_o |-> wake_valid_o);

  a_r7_wake_after_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_valid_o) |-> ($past(state_q) == ST_SWAIT && main_osc_en_o));

  a_r8_no_wake_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_valid_o && hst_ni) |-> !int_rst_o);
endmodule

bind stby_wake_seq sbw_checker #(.IRQ_W(IRQ_W)) i_sbw_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .hst_ni         (hst_ni),
  .ext_rst_i      (ext_rst_i),
  .irq_lvl_i      (irq_lvl_i),
  .main_osc_en_o  (main_osc_en_o),
  .sub_osc_en_o   (sub_osc_en_o),
  .io_hiz_o       (io_hiz_o),
  .reg_clr_o      (reg_clr_o),
  .int_rst_o      (int_rst_o),
  .wake_valid_o   (wake_valid_o),
  .wake_take_irq_o(wake_take_irq_o),
  .state_q        (state_q)
);

// File: tb/test_stby_wake_seq.sv
`timescale 1ns/1ps
module test_stby_wake_seq;
  localparam int SUB_WAIT = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, hst_ni = 1'b1, stop_req_i = 1'b0, sub_mode_i = 1'b0;
  logic ext_rst_i = 1'b0, irq_accept_i = 1'b0;
  logic [2:0] irq_lvl_i = 3'd7;
  logic [1:0] wait_sel_i = 2'd0;
  logic main_osc_en_o, sub_osc_en_o, io_hiz_o, reg_clr_o, int_rst_o;
  logic wake_valid_o, wake_take_irq_o;

  int checks = 0, errors = 0;
  bit saw_wake, saw_take;

  always #5 clk = ~clk;

  stby_wake_seq #(.SUB_WAIT_CYC(SUB_WAIT)) i_stby_wake_seq (
    .clk_i(clk), .rst_ni(rst_ni), .hst_ni(hst_ni), .stop_req_i(stop_req_i),
    .sub_mode_i(sub_mode_i), .ext_rst_i(ext_rst_i), .irq_lvl_i(irq_lvl_i),
    .irq_accept_i(irq_accept_i), .wait_sel_i(wait_sel_i),
    .main_osc_en_o(main_osc_en_o), .sub_osc_en_o(sub_osc_en_o), .io_hiz_o(io_hiz_o),
    .reg_clr_o(reg_clr_o), .int_rst_o(int_rst_o), .wake_valid_o(wake_valid_o),
    .wake_take_irq_o(wake_take_irq_o)
  );

  function automatic int main_n(input int sel);
    return 1 << (4 + 4 * sel);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // which: 0 wake_valid high, 1 int_rst high, 2 int_rst low
  task automatic count_until(input int which, output int n);
    n = 0;
    saw_wake = 0;
    saw_take = 0;
    for (int k = 0; k < 70000; k++) begin
      tick();
      n++;
      if (wake_valid_o) saw_wake = 1;
      if (wake_take_irq_o) saw_take = 1;
      if (which == 0 && wake_valid_o) break;
      if (which == 1 && int_rst_o) break;
      if (which == 2 && !int_rst_o) break;
    end
  endtask

  task automatic check_standby_outs(input string req);
    chk(io_hiz_o && reg_clr_o && int_rst_o && !main_osc_en_o && !sub_osc_en_o, req,
        {io_hiz_o, reg_clr_o, int_rst_o, main_osc_en_o, sub_osc_en_o}, 5'b11100);
  endtask

  task automatic enter_stop(input bit sub, input int sel);
    sub_mode_i = sub;
    wait_sel_i = 2'(sel);
    stop_req_i = 1'b1;
    tick();
    stop_req_i = 1'b0;
  endtask

  initial begin
    int n;
    #1;
    check_standby_outs("R1 reset state");
    @(negedge clk);
    @(negedge clk);
    wait_sel_i = 2'd0;
    rst_ni = 1'b1;
    count_until(2, n);
    chk(n == main_n(0) + 3, "R2 R5 boot release", n, main_n(0) + 3);
    chk(main_osc_en_o && sub_osc_en_o && !io_hiz_o && !reg_clr_o, "R2 run outputs",
        {main_osc_en_o, sub_osc_en_o, io_hiz_o, reg_clr_o}, 4'b1100);

    // R10 reset pulse in run
    ext_rst_i = 1'b1;
    tick();
    ext_rst_i = 1'b0;
    chk(int_rst_o == 1'b1, "R10 pulse high", int_rst_o, 1);
    tick();
    chk(int_rst_o == 1'b0, "R10 pulse one cycle", int_rst_o, 0);

    // main-stop interrupt wake for every select code
    for (int sel = 0; sel < 4; sel++) begin
      enter_stop(1'b0, sel);
      chk(!main_osc_en_o && sub_osc_en_o, "R3 main-stop oscillators",
          {main_osc_en_o, sub_osc_en_o}, 2'b01);
      for (int k = 0; k < 12; k++) tick();
      chk(!main_osc_en_o && !wake_valid_o, "R4 level 7 does not wake",
          {main_osc_en_o, wake_valid_o}, 0);
      irq_accept_i = sel[0];
      irq_lvl_i = 3'(sel + 2);
      count_until(0, n);
      irq_lvl_i = 3'd7;
      chk(n == main_n(sel) + 1, "R5 R7 main wait length", n, main_n(sel) + 1);
      chk(wake_take_irq_o == sel[0], "R7 take follows acceptance", wake_take_irq_o, sel[0]);
      chk(main_osc_en_o && !int_rst_o, "R7 resumed running", {main_osc_en_o, int_rst_o}, 2'b10);
      tick();
      chk(!wake_valid_o && !wake_take_irq_o, "R7 wake one cycle",
          {wake_valid_o, wake_take_irq_o}, 0);
    end

    // R9: disturbances mid-wait do not restart, shorten or re-cause
    enter_stop(1'b0, 1);
    irq_accept_i = 1'b1;
    irq_lvl_i = 3'd0;
    tick();
    irq_lvl_i = 3'd7;
    for (int k = 0; k < 19; k++) begin
      wait_sel_i = 2'(k % 4);
      ext_rst_i = k[0];
      irq_lvl_i = k[1] ? 3'd1 : 3'd7;
      tick();
    end
    ext_rst_i = 1'b0;
    irq_lvl_i = 3'd7;
    count_until(0, n);
    chk(n + 20 == main_n(1) + 1, "R9 wait not restarted", n + 20, main_n(1) + 1);
    chk(wake_valid_o && wake_take_irq_o, "R9 cause kept as interrupt",
        {wake_valid_o, wake_take_irq_o}, 2'b11);

    // sub-stop, reset and interrupt together: reset wins
    enter_stop(1'b1, 3);
    chk(!main_osc_en_o && !sub_osc_en_o, "R3 sub-stop oscillators",
        {main_osc_en_o, sub_osc_en_o}, 0);
    ext_rst_i = 1'b1;
    irq_lvl_i = 3'd2;
    tick();
    ext_rst_i = 1'b0;
    irq_lvl_i = 3'd7;
    count_until(1, n);
    chk(n + 1 == SUB_WAIT + 1, "R6 sub wait length", n + 1, SUB_WAIT + 1);
    chk(!saw_wake, "R8 reset wins, no wake status", saw_wake, 0);
    tick();
    chk(!int_rst_o, "R8 reset pulse one cycle", int_rst_o, 0);

    // main-stop reset-caused exit
    enter_stop(1'b0, 0);
    ext_rst_i = 1'b1;
    tick();
    ext_rst_i = 1'b0;
    count_until(1, n);
    chk(n + 1 == main_n(0) + 1, "R8 main reset wait", n + 1, main_n(0) + 1);
    chk(!saw_wake, "R8 no wake status", saw_wake, 0);

    // hardware standby from run, no edge needed
    hst_ni = 1'b0;
    #1;
    check_standby_outs("R1 async standby from run");
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      stop_req_i = k[0];
      ext_rst_i = k[1];
      irq_lvl_i = k[2] ? 3'd0 : 3'd7;
      tick();
    end
    stop_req_i = 1'b0;
    ext_rst_i = 1'b0;
    irq_lvl_i = 3'd7;
    check_standby_outs("R2 inputs ignored in standby");
    wait_sel_i = 2'd2;
    hst_ni = 1'b1;
    count_until(2, n);
    chk(n == main_n(2) + 3, "R2 R5 standby release", n, main_n(2) + 3);

    // standby during a stop wait
    enter_stop(1'b0, 1);
    irq_lvl_i = 3'd3;
    tick();
    irq_lvl_i = 3'd7;
    for (int k = 0; k < 5; k++) tick();
    #2;
    hst_ni = 1'b0;
    #1;
    check_standby_outs("R1 async standby mid-wait");
    @(negedge clk);
    tick();
    tick();
    wait_sel_i = 2'd0;
    hst_ni = 1'b1;
    count_until(2, n);
    chk(n == main_n(0) + 3, "R2 release after mid-wait standby", n, main_n(0) + 3);
    chk(!saw_wake, "R2 interrupted wait gives no wake", saw_wake, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule